// File: doc/BRIEF.md
# CCM Nonce and Block Formatter

This block prepares every 128-bit input block that a CCM cipher core needs to protect one wireless frame. Once per frame it captures a priority octet, a 48-bit transmitter address, a 48-bit packet number, the payload length in octets and a flag saying whether additional authenticated data is present. It packs the first three into a 13-octet nonce. It then emits the initial authentication block, the counter block reserved for masking the tag, and the payload. The payload arrives one octet at a time and leaves as 16-octet blocks, each followed by its own counter block.

All blocks leave through one valid/ready port. A kind tag tells the downstream engine which datapath a block belongs to: the authentication-chain start, the counter path, or payload, which feeds both paths. Payload blocks carry an octet count so that the counter path can trim the last partial block. The authentication path uses the zero padding as it stands. The CCM parameters are fixed: an 8-octet tag and a 2-octet length field. The cipher, packet-number management and header processing are done elsewhere.

Top module: `ccm_block_fmt`

## Requirements
- R1: After reset, blk_valid, pay_ready, busy and frame_done are all low, and they stay low until a frame is started.
- R2: A frame_start seen while busy is low captures the fields. From the next cycle, nonce holds, from the most significant octet down, the priority octet, then the six address octets, then the six packet-number octets with the most significant octet first. It keeps that value until the next accepted start.
- R3: The first block of a frame has kind 0. Its top octet is the flags value 0x59 when aad_present was set and 0x19 when it was clear (reserved bit 7 zero, AAD bit 6, tag code (8-2)/2 in bits 5:3, length code 2-1 in bits 2:0). The 13-octet nonce follows, then the payload length as a 16-bit big-endian value in the lowest two octets.
- R4: Counter blocks have kind 1. Their top octet is 0x01, the nonce follows, and a 16-bit big-endian counter value fills the lowest two octets.
- R5: Payload blocks have kind 2. The first octet received occupies bits 127:120, the next octet bits 119:112, and so on. blk_octets gives the number of real octets (16, or the remainder for the last block). The octets beyond that count are zero.
- R6: A frame emits its blocks in this order: the initial block, the counter block with value 0, then for each payload block i (i = 1, 2, ...) that payload block followed by the counter block with value i. A zero-length frame emits only the first two.
- R7: While blk_valid is high and blk_ready is low, blk_valid, blk_kind, blk_data and blk_octets stay unchanged in the next cycle.
- R8: pay_ready is high only while the block is gathering payload. Exactly the number of octets given by pay_len is taken per frame, and octets offered beyond that are left untaken.
- R9: frame_done is high for exactly one cycle. That cycle is the one right after the handshake of the frame's last counter block, and busy is low in it.
- R10: A frame_start raised while busy is high has no effect: the nonce and the remaining block sequence are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Start request; fields below are captured when idle |
| prio | input | 8 | Priority octet |
| addr | input | 48 | Transmitter address |
| pkt_num | input | 48 | Packet number |
| pay_len | input | 16 | Payload length in octets |
| aad_present | input | 1 | Additional authenticated data will be chained |
| pay_valid | input | 1 | Payload octet offered |
| pay_octet | input | 8 | Payload octet |
| pay_ready | output | 1 | Payload octet taken this cycle when pay_valid is high |
| blk_valid | output | 1 | Block offered downstream |
| blk_ready | input | 1 | Downstream accepts the block |
| blk_kind | output | 2 | 0 initial block, 1 counter block, 2 payload block |
| blk_data | output | 128 | Block contents, first octet in bits 127:120 |
| blk_octets | output | 5 | Real octets in the block (16 except for a short last payload block) |
| nonce | output | 104 | Captured nonce of the current frame |
| busy | output | 1 | A frame is in progress |
| frame_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The end-of-frame pulse and the capture of the next frame's fields can fall in the same cycle, because frame_done is high in the first idle cycle. The bench starts each following frame in exactly that cycle. It then judges that the pulse is still single, that the new nonce appears one cycle later, and that the new frame's first block comes out correct. A start raised in the middle of a long stalled frame is also compared against the unchanged block stream and nonce.

// File: rtl/ccm_fmt_pkg.sv
package ccm_fmt_pkg;
    // Fixed CCM parameters for this frame format
    localparam int TAG_OCTETS   = 8;
    localparam int LEN_OCTETS   = 2;
    localparam int BLK_OCTETS   = 16;
    localparam int NONCE_OCTETS = 15 - LEN_OCTETS;
    localparam int PN_OCTETS    = 6;
    localparam int ADDR_OCTETS  = 6;

    localparam int BLK_W   = BLK_OCTETS * 8;
    localparam int NONCE_W = NONCE_OCTETS * 8;
    localparam int LEN_W   = LEN_OCTETS * 8;
    localparam int PN_W    = PN_OCTETS * 8;
    localparam int ADDR_W  = ADDR_OCTETS * 8;
    localparam int CNT_W   = $clog2(BLK_OCTETS + 1);

    localparam logic [2:0] TAG_CODE = 3'((TAG_OCTETS - 2) / 2);
    localparam logic [2:0] LEN_CODE = 3'(LEN_OCTETS - 1);

    typedef enum logic [1:0] {
        KIND_B0  = 2'd0,
        KIND_CTR = 2'd1,
        KIND_PAY = 2'd2
    } blk_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_B0   = 3'd1,
        ST_CTR  = 3'd2,
        ST_GATH = 3'd3,
        ST_PAY  = 3'd4
    } fmt_state_e;

    typedef struct packed {
        fmt_state_e         st;
        logic [NONCE_W-1:0] nonce;
        logic [LEN_W-1:0]   total;
        logic [LEN_W-1:0]   remain;
        logic [LEN_W-1:0]   ctr;
        logic               aad;
        logic               done;
    } fmt_regs_t;

    typedef struct packed {
        logic [BLK_W-1:0] acc;
        logic [CNT_W-1:0] cnt;
    } gath_regs_t;

    function automatic logic [7:0] auth_flags(input logic aad);
        return {1'b0, aad, TAG_CODE, LEN_CODE};
    endfunction

    function automatic logic [7:0] ctr_flags();
        return {5'b0, LEN_CODE};
    endfunction
endpackage

// File: rtl/ccm_nonce_pack.sv
module ccm_nonce_pack
    import ccm_fmt_pkg::*;
(
    input  logic [7:0]         prio,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [PN_W-1:0]    pkt_num,
    output logic [NONCE_W-1:0] nonce
);
    localparam int PN_LSB   = 0;
    localparam int ADDR_LSB = PN_W;
    localparam int PRIO_LSB = PN_W + ADDR_W;

    // Octet-wise placement, most significant octet of each field first
    for (genvar a = 0; a < ADDR_OCTETS; a++) begin : g_addr
        assign nonce[ADDR_LSB + 8*a +: 8] = addr[8*a +: 8];
    end
    for (genvar p = 0; p < PN_OCTETS; p++) begin : g_pn
        assign nonce[PN_LSB + 8*p +: 8] = pkt_num[8*p +: 8];
    end
    assign nonce[PRIO_LSB +: 8] = prio;
endmodule

// File: rtl/ccm_octet_gather.sv
module ccm_octet_gather
    import ccm_fmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CNT_W-1:0] want,
    input  logic             in_valid,
    input  logic [7:0]       in_octet,
    output logic             in_ready,
    input  logic             consume,
    output logic             full,
    output logic [BLK_W-1:0] blk
);
    gath_regs_t r_q, r_d;

    assign in_ready = enable && (r_q.cnt < want);
    assign full     = enable && (want != '0) && (r_q.cnt == want);
    assign blk      = r_q.acc;

    always_comb begin
        r_d = r_q;
        if (consume) begin
            // Clearing leaves the zero padding for the next block
            r_d.acc = '0;
            r_d.cnt = '0;
        end else if (in_ready && in_valid) begin
            r_d.acc[BLK_W - 1 - 8*int'(r_q.cnt) -: 8] = in_octet;
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/ccm_block_build.sv
module ccm_block_build
    import ccm_fmt_pkg::*;
(
    input  blk_kind_e          kind,
    input  logic [NONCE_W-1:0] nonce,
    input  logic               aad,
    input  logic [LEN_W-1:0]   total,
    input  logic [LEN_W-1:0]   ctr,
    input  logic [BLK_W-1:0]   pay_blk,
    output logic [BLK_W-1:0]   blk
);
    always_comb begin
        case (kind)
            KIND_B0:  blk = {auth_flags(aad), nonce, total};
            KIND_CTR: blk = {ctr_flags(), nonce, ctr};
            default:  blk = pay_blk;
        endcase
    end
endmodule

// File: rtl/ccm_block_fmt.sv
module ccm_block_fmt
    import ccm_fmt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start,
    input  logic [7:0]         prio,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [PN_W-1:0]    pkt_num,
    input  logic [LEN_W-1:0]   pay_len,
    input  logic               aad_present,
    input  logic               pay_valid,
    input  logic [7:0]         pay_octet,
    output logic               pay_ready,
    output logic               blk_valid,
    input  logic               blk_ready,
    output logic [1:0]         blk_kind,
    output logic [BLK_W-1:0]   blk_data,
    output logic [CNT_W-1:0]   blk_octets,
    output logic [NONCE_W-1:0] nonce,
    output logic               busy,
    output logic               frame_done
);
    fmt_regs_t r_q, r_d;

    logic [NONCE_W-1:0] nonce_in;
    logic [CNT_W-1:0]   want;
    logic               gath_en;
    logic               gath_full;
    logic               consume;
    logic [BLK_W-1:0]   pay_blk;
    blk_kind_e          kind;

    ccm_nonce_pack u_nonce (
        .prio    (prio),
        .addr    (addr),
        .pkt_num (pkt_num),
        .nonce   (nonce_in)
    );

    // Octets for the block being gathered: a full block or the remainder
    assign want = (r_q.remain >= LEN_W'(BLK_OCTETS)) ? CNT_W'(BLK_OCTETS)
                                                     : r_q.remain[CNT_W-1:0];

    assign gath_en = (r_q.st == ST_GATH) || (r_q.st == ST_PAY);
    assign consume = (r_q.st == ST_PAY) && blk_ready;

    ccm_octet_gather u_gath (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (gath_en),
        .want     (want),
        .in_valid (pay_valid),
        .in_octet (pay_octet),
        .in_ready (pay_ready),
        .consume  (consume),
        .full     (gath_full),
        .blk      (pay_blk)
    );

    always_comb begin
        case (r_q.st)
            ST_B0:   kind = KIND_B0;
            ST_PAY:  kind = KIND_PAY;
            default: kind = KIND_CTR;
        endcase
    end

    ccm_block_build u_build (
        .kind    (kind),
        .nonce   (r_q.nonce),
        .aad     (r_q.aad),
        .total   (r_q.total),
        .ctr     (r_q.ctr),
        .pay_blk (pay_blk),
        .blk     (blk_data)
    );

    assign blk_valid  = (r_q.st == ST_B0) || (r_q.st == ST_CTR) || (r_q.st == ST_PAY);
    assign blk_kind   = kind;
    assign blk_octets = (r_q.st == ST_PAY) ? want : CNT_W'(BLK_OCTETS);
    assign nonce      = r_q.nonce;
    assign busy       = (r_q.st != ST_IDLE);
    assign frame_done = r_q.done;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (frame_start) begin
                    r_d.nonce  = nonce_in;
                    r_d.total  = pay_len;
                    r_d.remain = pay_len;
                    r_d.aad    = aad_present;
                    r_d.ctr    = '0;
                    r_d.st     = ST_B0;
                end
            end
            ST_B0: begin
                if (blk_ready) r_d.st = ST_CTR;
            end
            ST_CTR: begin
                if (blk_ready) begin
                    if (r_q.remain == '0) begin
                        r_d.done = 1'b1;
                        r_d.st   = ST_IDLE;
                    end else begin
                        r_d.ctr = r_q.ctr + 1'b1;
                        r_d.st  = ST_GATH;
                    end
                end
            end
            ST_GATH: begin
                if (gath_full) r_d.st = ST_PAY;
            end
            ST_PAY: begin
                if (blk_ready) begin
                    r_d.remain = r_q.remain - LEN_W'(want);
                    r_d.st     = ST_CTR;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/ccm_block_fmt_chk.sv
module ccm_block_fmt_chk
    import ccm_fmt_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               frame_start,
    input logic               pay_ready,
    input logic               blk_valid,
    input logic               blk_ready,
    input logic [1:0]         blk_kind,
    input logic [BLK_W-1:0]   blk_data,
    input logic [CNT_W-1:0]   blk_octets,
    input logic [NONCE_W-1:0] nonce,
    input logic               busy,
    input logic               frame_done
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!blk_valid && !pay_ready));

    // R2
    nonce_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(nonce));

    // R4
    ctr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_valid && blk_kind == KIND_CTR) |-> (blk_data[BLK_W-1 -: 8] == 8'h01));

    // R5
    pay_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_valid && blk_kind == KIND_PAY) |-> (blk_octets != '0 && blk_octets <= CNT_W'(BLK_OCTETS)));

    // R6
    first_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !busy) |=> (blk_valid && blk_kind == KIND_B0));

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_valid && !blk_ready) |=> (blk_valid && $stable(blk_data) && $stable(blk_kind) && $stable(blk_octets)));

    // R8
    pay_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pay_ready |-> (busy && !blk_valid));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !busy);
endmodule

bind ccm_block_fmt ccm_block_fmt_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .pay_ready   (pay_ready),
    .blk_valid   (blk_valid),
    .blk_ready   (blk_ready),
    .blk_kind    (blk_kind),
    .blk_data    (blk_data),
    .blk_octets  (blk_octets),
    .nonce       (nonce),
    .busy        (busy),
    .frame_done  (frame_done)
);

// File: tb/sim_ccm_block_fmt.sv
`timescale 1ns/1ps
module sim_ccm_block_fmt;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         frame_start = 1'b0;
    logic [7:0]   prio = '0;
    logic [47:0]  addr = '0;
    logic [47:0]  pkt_num = '0;
    logic [15:0]  pay_len = '0;
    logic         aad_present = 1'b0;
    logic         pay_valid = 1'b0;
    logic [7:0]   pay_octet = '0;
    logic         pay_ready;
    logic         blk_valid;
    logic         blk_ready = 1'b0;
    logic [1:0]   blk_kind;
    logic [127:0] blk_data;
    logic [4:0]   blk_octets;
    logic [103:0] nonce;
    logic         busy;
    logic         frame_done;

    ccm_block_fmt u0 (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .prio(prio),
        .addr(addr), .pkt_num(pkt_num), .pay_len(pay_len), .aad_present(aad_present),
        .pay_valid(pay_valid), .pay_octet(pay_octet), .pay_ready(pay_ready),
        .blk_valid(blk_valid), .blk_ready(blk_ready), .blk_kind(blk_kind),
        .blk_data(blk_data), .blk_octets(blk_octets), .nonce(nonce),
        .busy(busy), .frame_done(frame_done)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        logic [127:0] data;
        int           kind;
        int           octs;
    } exp_blk_t;

    exp_blk_t     expq[$];
    logic [7:0]   octq[$];
    int           checks = 0;
    int           errors = 0;
    int           ready_mode = 0;
    int           gap_mode = 0;
    bit           done_pending = 0;
    bit           stall_prev = 0;
    logic [127:0] held_data;
    logic [1:0]   held_kind;
    logic [4:0]   held_octs;
    int           cycles = 0;

    function automatic logic [103:0] ref_nonce(logic [7:0] p, logic [47:0] a, logic [47:0] n);
        logic [103:0] v;
        v[103:96] = p;
        for (int k = 0; k < 6; k++) v[95 - 8*k -: 8] = a[47 - 8*k -: 8];
        for (int k = 0; k < 6; k++) v[47 - 8*k -: 8] = n[47 - 8*k -: 8];
        return v;
    endfunction

    task automatic fail_line(string req, string what, logic [127:0] act, logic [127:0] exp);
        errors++;
        $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    endtask

    // Per-cycle comparison against the queued expectation
    always @(negedge clk) begin
        case (ready_mode)
            0: blk_ready = 1'b1;
            1: blk_ready = ($urandom % 2) == 0;
            default: blk_ready = ($urandom % 4) == 0;
        endcase
        pay_valid = (octq.size() > 0) && (gap_mode == 0 || ($urandom % 3) != 0);
        pay_octet = (octq.size() > 0) ? octq[0] : 8'h00;
        #1;
        if (rst_n) begin
            cycles++;
            if (stall_prev) begin
                checks++;
                if (!blk_valid || blk_data !== held_data || blk_kind !== held_kind || blk_octets !== held_octs)
                    fail_line("R7", "stalled block changed", blk_data, held_data);
            end
            stall_prev = blk_valid && !blk_ready;
            held_data  = blk_data;
            held_kind  = blk_kind;
            held_octs  = blk_octets;
            if (done_pending) begin
                checks++;
                if (frame_done !== 1'b1 || busy !== 1'b0)
                    fail_line("R9", "frame_done/busy", {126'b0, frame_done, busy}, 128'h2);
                done_pending = 0;
            end else if (frame_done !== 1'b0) begin
                fail_line("R9", "stray frame_done", 128'(frame_done), 128'h0);
            end
            if (pay_ready && !busy)
                fail_line("R8", "pay_ready while idle", 128'(pay_ready), 128'h0);
            if (blk_valid && blk_ready) begin
                checks++;
                if (expq.size() == 0) begin
                    fail_line("R6", "unexpected block", blk_data, 128'h0);
                end else begin
                    exp_blk_t e;
                    e = expq.pop_front();
                    if (int'(blk_kind) != e.kind)
                        fail_line("R6", "block kind", 128'(blk_kind), 128'(e.kind));
                    else if (blk_data !== e.data || int'(blk_octets) != e.octs)
                        fail_line(e.kind == 0 ? "R3" : (e.kind == 1 ? "R4" : "R5"),
                                  "block contents", {blk_data[127:8], 3'b0, blk_octets},
                                  {e.data[127:8], 3'b0, 5'(e.octs)});
                    if (expq.size() == 0) done_pending = 1;
                end
            end
            if (pay_valid && pay_ready) void'(octq.pop_front());
        end
    end

    task automatic run_frame(logic [7:0] p, logic [47:0] a, logic [47:0] n, int len,
                             logic aadf, int rmode, int gmode, bit intrude);
        logic [103:0] nv;
        int           nblk;
        nv = ref_nonce(p, a, n);
        octq.delete();
        for (int j = 0; j < len; j++) octq.push_back(8'((j * 13 + int'(p) * 7 + 5) & 255));
        for (int j = 0; j < 3; j++) octq.push_back(8'hEE);
        begin
            exp_blk_t e;
            e.data = {(aadf ? 8'h59 : 8'h19), nv, 16'(len)}; e.kind = 0; e.octs = 16;
            expq.push_back(e);
            e.data = {8'h01, nv, 16'h0000}; e.kind = 1; e.octs = 16;
            expq.push_back(e);
            nblk = (len + 15) / 16;
            for (int b = 0; b < nblk; b++) begin
                int cnt;
                cnt = (len - 16*b > 16) ? 16 : len - 16*b;
                e.data = '0;
                for (int k = 0; k < cnt; k++)
                    e.data[127 - 8*k -: 8] = octq[16*b + k];
                e.kind = 2; e.octs = cnt;
                expq.push_back(e);
                e.data = {8'h01, nv, 16'(b + 1)}; e.kind = 1; e.octs = 16;
                expq.push_back(e);
            end
        end
        ready_mode = rmode;
        gap_mode   = gmode;
        @(negedge clk);
        frame_start = 1'b1; prio = p; addr = a; pkt_num = n;
        pay_len = 16'(len); aad_present = aadf;
        @(negedge clk);
        frame_start = 1'b0; prio = ~p; addr = ~a; pkt_num = ~n; pay_len = 16'hFFFF;
        #1;
        checks++;
        if (nonce !== nv) fail_line("R2", "captured nonce", 128'(nonce), 128'(nv));
        if (intrude) begin
            repeat (6) @(negedge clk);
            frame_start = 1'b1; prio = 8'hA5; addr = 48'h1; pkt_num = 48'h2; pay_len = 16'd3;
            @(negedge clk);
            frame_start = 1'b0;
            #1;
            checks++;
            if (!busy || nonce !== nv) fail_line("R10", "start while busy", 128'(nonce), 128'(nv));
        end
        do begin
            @(negedge clk);
            #2;
        end while (!(expq.size() == 0 && done_pending) && cycles < 100000);
        checks++;
        if (octq.size() != 3)
            fail_line("R8", "octets left untaken", 128'(octq.size()), 128'd3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        checks++;
        if (blk_valid || pay_ready || busy || frame_done)
            fail_line("R1", "reset outputs", {blk_valid, pay_ready, busy, frame_done}, 128'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        checks++;
        if (blk_valid || pay_ready || busy || frame_done)
            fail_line("R1", "idle outputs", {blk_valid, pay_ready, busy, frame_done}, 128'h0);
        // R6 zero-length frame, R3 with AAD
        run_frame(8'h03, 48'h0A1B2C3D4E5F, 48'h000000000001, 0, 1'b1, 0, 0, 0);
        // R5 single octet, next start coincides with frame_done (R9)
        run_frame(8'h07, 48'h112233445566, 48'hFFEEDDCCBBAA, 1, 1'b1, 1, 0, 0);
        // R3 flags without AAD, exact block
        run_frame(8'h00, 48'h665544332211, 48'h123456789ABC, 16, 1'b0, 0, 0, 0);
        // R5 block boundary plus one, octet gaps
        run_frame(8'h0F, 48'hDEADBEEF0001, 48'h00000000FFFF, 17, 1'b1, 1, 1, 0);
        // R7 heavy stalls
        run_frame(8'h02, 48'hCAFEF00D1234, 48'h800000000000, 33, 1'b0, 2, 1, 0);
        // R10 start while busy, R4 counters up to 4
        run_frame(8'h05, 48'h0102030405A6, 48'h0000ABCD0000, 64, 1'b1, 2, 0, 1);
        // R6 back-to-back short frame
        run_frame(8'h01, 48'h1F2E3D4C5B6A, 48'h00000000000F, 5, 1'b1, 0, 0, 0);
        repeat (3) @(negedge clk);
        #1;
        checks++;
        if (busy || blk_valid || frame_done)
            fail_line("R1", "quiet after frames", {busy, blk_valid, frame_done}, 128'h0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #600000;
        errors++;
        $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule